// File: doc/BRIEF.md
# Sticky Interrupt Flag Register

This block holds six interrupt flags for a mixed-signal motor or bus controller. The flags sit in one 8-bit register. Each flag latches an event or a condition and holds it until software clears it. There are four kinds of source. The Hall sensor inputs are watched for activity. The serial bus receive line is watched for a falling edge. Three level conditions are watched: over-temperature, under-voltage and over-voltage. Three over-current sources each have their own flag.

Software reads the register and clears flags by writing 1 to their bit positions. Writing 0 leaves a bit as it is. A level flag cannot be cleared while its condition is still present, so no event is lost. The over-current bit is read-only. It shows the OR of three over-current flags, which are cleared through a separate status-clear port. One interrupt request output is high whenever a flag is set and its enable bit is on.

The Hall flag has two modes. In run mode it sets when an enabled input changes state. In stop mode it sets when wake-up is enabled and an enabled input is high. All inputs are taken as already synchronized to the clock. The asynchronous reset input is released through an internal two-stage synchronizer.

Top module: `sticky_irq_flags`

## Requirements
- R1: After reset, `reg_rdata`, `oc_flags` and `irq` are all zero.
- R2: The bit layout is as follows. Bit 6 is the Hall flag, bit 5 the bus-edge flag, bit 4 over-temperature, bit 3 under-voltage, bit 2 over-voltage and bit 1 over-current. Bits 7 and 0 always read 0, whatever is written to them.
- R3: A write with a 1 in bit 6 or bit 5 clears that flag on the next clock edge. A write with a 0 in a bit leaves that bit unchanged.
- R4: The bus-edge flag sets on the clock edge that first samples `bus_rx` low after a high sample, and then stays set. A rising edge does not set it.
- R5: In run mode (`stop_mode`=0), the Hall flag sets when any Hall input whose `hall_en` bit is 1 differs from its value at the previous clock edge. Changes on disabled inputs are ignored.
- R6: In stop mode (`stop_mode`=1), the Hall flag sets only when `wake_en`=1 and an enabled Hall input is high. With `wake_en`=0 it does not set.
- R7: Bits 4, 3 and 2 set on any clock edge where `temp_hi`, `volt_lo` or `volt_hi` is high. A write-1 clear is ignored while that condition is still high. Once the condition is gone, the clear takes effect.
- R8: Bit 1 reads as the OR of `oc_flags`. A write to bit 1 has no effect.
- R9: `oc_flags[i]` sets on `oc_evt[i]`. It clears on a clock edge where `oc_clr_we`=1 and `oc_clr_data[i]`=1. A 0 in `oc_clr_data` leaves the flag unchanged. The flags are, in index order, the supply output, the high side and the half bridge.
- R10: When a set event and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when some bit k of `irq_mask` is 1 and register bit k+1 is 1 (mask order {hall, bus, temp, uv, ov, oc}).
- R12: `reg_rdata` shows the registered state. In a write cycle it still shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | 1 selects stop-mode Hall behaviour |
| wake_en | input | 1 | Stop-mode Hall wake-up enable |
| hall_en | input | HALL_N | Per-input Hall enable |
| hall_in | input | HALL_N | Hall sensor inputs |
| bus_rx | input | 1 | Serial bus receive line |
| temp_hi | input | 1 | Over-temperature condition |
| volt_lo | input | 1 | Under-voltage condition |
| volt_hi | input | 1 | Over-voltage condition |
| oc_evt | input | OC_N | Over-current events {half bridge, high side, supply} |
| oc_clr_we | input | 1 | Status-clear strobe for the over-current flags |
| oc_clr_data | input | OC_N | Write-1 clear mask for the over-current flags |
| oc_flags | output | OC_N | Over-current flags |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_mask | input | 6 | Per-flag interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Every flag is visible on `reg_rdata` and `oc_flags` one clock edge after the input or write that caused it. `irq` follows the flags and the mask in the same cycle, with no extra register. The bench drives its inputs on the falling edge and compares on the next falling edge. The reference model is updated on the rising edge in between, so each result is checked exactly one edge after its stimulus. For the same-cycle read rule, the bench samples `reg_rdata` in the write cycle itself, before the edge that applies the write.

// File: rtl/irqf_pkg.sv
`timescale 1ns/1ps
package irqf_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_HALL = 6;
  localparam int BIT_BUS  = 5;
  localparam int BIT_TEMP = 4;
  localparam int BIT_UV   = 3;
  localparam int BIT_OV   = 2;
  localparam int BIT_OC   = 1;
  localparam int NUM_FLAGS = BIT_HALL - BIT_OC + 1;
  localparam int NUM_STICKY = NUM_FLAGS - 1;
endpackage

// File: rtl/irqf_rst_sync.sv
`timescale 1ns/1ps
module irqf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqf_sticky.sv
`timescale 1ns/1ps
module irqf_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] q_nxt;
  logic         upd_en;

  always_comb begin
    q_nxt  = set_i | (q & ~clr_i);
    upd_en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_nxt;
  end

  assign q_o = q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_set_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
  end
endmodule

// File: rtl/irqf_detect.sv
`timescale 1ns/1ps
module irqf_detect #(
  parameter int HALL_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_mode,
  input  logic              wake_en,
  input  logic [HALL_N-1:0] hall_en,
  input  logic [HALL_N-1:0] hall_in,
  input  logic              bus_rx,
  output logic              hall_evt,
  output logic              bus_fall
);
  logic [HALL_N-1:0] hall_q;
  logic              bus_q;
  logic              run_evt;
  logic              stop_evt;

  always_comb begin
    run_evt  = |((hall_in ^ hall_q) & hall_en);
    stop_evt = wake_en & (|(hall_in & hall_en));
    hall_evt = stop_mode ? stop_evt : run_evt;
    bus_fall = bus_q & ~bus_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_q <= '0;
      bus_q  <= 1'b1;
    end else begin
      hall_q <= hall_in;
      bus_q  <= bus_rx;
    end
  end

  assert_stop_gate_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !wake_en) |-> !hall_evt);
  assert_run_masked_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && hall_en == '0) |-> !hall_evt);
endmodule

// File: rtl/sticky_irq_flags.sv
`timescale 1ns/1ps
module sticky_irq_flags
  import irqf_pkg::*;
#(
  parameter int HALL_N = 3,
  parameter int OC_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_mode,
  input  logic              wake_en,
  input  logic [HALL_N-1:0] hall_en,
  input  logic [HALL_N-1:0] hall_in,
  input  logic              bus_rx,
  input  logic              temp_hi,
  input  logic              volt_lo,
  input  logic              volt_hi,
  input  logic [OC_N-1:0]   oc_evt,
  input  logic              oc_clr_we,
  input  logic [OC_N-1:0]   oc_clr_data,
  output logic [OC_N-1:0]   oc_flags,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_FLAGS-1:0] irq_mask,
  output logic              irq
);
  logic rst_i;
  logic hall_evt;
  logic bus_fall;
  logic [NUM_STICKY-1:0] st_set;
  logic [NUM_STICKY-1:0] st_clr;
  logic [NUM_STICKY-1:0] st_q;
  logic [NUM_STICKY-1:0] st_cond;
  logic [NUM_STICKY-1:0] w1c;
  logic [OC_N-1:0]       oc_clr;
  logic [NUM_FLAGS-1:0]  flag_vec;

  irqf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  irqf_detect #(.HALL_N(HALL_N)) u_det (
    .clk(clk), .rst_n(rst_i), .stop_mode(stop_mode), .wake_en(wake_en),
    .hall_en(hall_en), .hall_in(hall_in), .bus_rx(bus_rx),
    .hall_evt(hall_evt), .bus_fall(bus_fall));

  // sticky vector order, MSB first: hall, bus, temp, uv, ov
  always_comb begin
    st_set  = {hall_evt, bus_fall, temp_hi, volt_lo, volt_hi};
    st_cond = {2'b00, temp_hi, volt_lo, volt_hi};
    w1c     = reg_we ? reg_wdata[BIT_HALL:BIT_OV] : '0;
    st_clr  = w1c & ~st_cond;
    oc_clr  = oc_clr_we ? oc_clr_data : '0;
  end

  irqf_sticky #(.W(NUM_STICKY)) u_flags (
    .clk(clk), .rst_n(rst_i), .set_i(st_set), .clr_i(st_clr), .q_o(st_q));

  irqf_sticky #(.W(OC_N)) u_ocf (
    .clk(clk), .rst_n(rst_i), .set_i(oc_evt), .clr_i(oc_clr), .q_o(oc_flags));

  always_comb begin
    flag_vec  = {st_q, |oc_flags};
    reg_rdata = {1'b0, flag_vec, 1'b0};
    irq       = |(flag_vec & irq_mask);
  end

  assert_bus_fall_R4 : assert property (@(posedge clk) disable iff (!rst_i)
    $fell(bus_rx) |=> reg_rdata[BIT_BUS]);
  assert_w1c_R3 : assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && reg_wdata[BIT_BUS] && !bus_fall) |=> !reg_rdata[BIT_BUS]);
  assert_level_hold_R7 : assert property (@(posedge clk) disable iff (!rst_i)
    (temp_hi || volt_lo || volt_hi) |=>
      ((reg_rdata[BIT_TEMP] || !$past(temp_hi)) &&
       (reg_rdata[BIT_UV]   || !$past(volt_lo)) &&
       (reg_rdata[BIT_OV]   || !$past(volt_hi))));
  assert_ocf_or_R8 : assert property (@(posedge clk) disable iff (!rst_i)
    reg_rdata[BIT_OC] == (oc_flags != '0));
  assert_ro_bit_R8 : assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && reg_wdata[BIT_OC] && !oc_clr_we && oc_evt == '0) |=> $stable(reg_rdata[BIT_OC]));
  assert_reserved_R2 : assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && (reg_wdata[REG_W-1] || reg_wdata[0])) |=> (!reg_rdata[REG_W-1] && !reg_rdata[0]));
endmodule

// File: tb/sticky_irq_flags_tb.sv
`timescale 1ns/1ps
module sticky_irq_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_mode = 0, wake_en = 0, bus_rx = 1, temp_hi = 0, volt_lo = 0, volt_hi = 0;
  logic [2:0] hall_en = 3'b111, hall_in = 3'b000;
  logic [2:0] oc_evt = 0, oc_clr_data = 0;
  logic oc_clr_we = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [5:0] irq_mask = 6'b111111;
  logic [2:0] oc_flags;
  logic [7:0] reg_rdata;
  logic irq;

  int total = 0, bad = 0;
  bit model_on = 0, done = 0;

  // behavioural reference state
  bit m_hall, m_bus, m_temp, m_uv, m_ov;
  bit [2:0] m_oc;
  bit [2:0] m_hprev;
  bit m_bprev = 1;

  always #10 clk = ~clk;

  sticky_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .wake_en(wake_en),
    .hall_en(hall_en), .hall_in(hall_in), .bus_rx(bus_rx), .temp_hi(temp_hi),
    .volt_lo(volt_lo), .volt_hi(volt_hi), .oc_evt(oc_evt), .oc_clr_we(oc_clr_we),
    .oc_clr_data(oc_clr_data), .oc_flags(oc_flags), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask), .irq(irq));

  function automatic bit [7:0] m_rd();
    return {1'b0, m_hall, m_bus, m_temp, m_uv, m_ov, (m_oc != 0), 1'b0};
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      bit hev;
      bit [7:0] c;
      c = reg_we ? reg_wdata : 8'h00;
      if (stop_mode) hev = wake_en && ((hall_in & hall_en) != 0);
      else           hev = ((hall_in ^ m_hprev) & hall_en) != 0;
      m_hall = hev || (m_hall && !c[6]);
      m_bus  = (m_bprev && !bus_rx) || (m_bus && !c[5]);
      m_temp = temp_hi || (m_temp && !c[4]);
      m_uv   = volt_lo || (m_uv && !c[3]);
      m_ov   = volt_hi || (m_ov && !c[2]);
      for (int i = 0; i < 3; i++)
        m_oc[i] = oc_evt[i] || (m_oc[i] && !(oc_clr_we && oc_clr_data[i]));
      m_hprev = hall_in;
      m_bprev = bus_rx;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    bit [7:0] er;
    er = m_rd();
    check("R2/R12 model rdata", {24'd0, reg_rdata}, {24'd0, er});
    check("R9 model oc_flags", {29'd0, oc_flags}, {29'd0, m_oc});
    check("R11 model irq", {31'd0, irq}, {31'd0, |(er[6:1] & irq_mask)});
  endtask

  // one clock: compare at falling edge, then apply new inputs
  task automatic step();
    @(negedge clk);
    if (model_on) model_cmp();
  endtask

  task automatic idle_bus();
    reg_we = 0; reg_wdata = 0; oc_evt = 0; oc_clr_we = 0; oc_clr_data = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset rdata", {24'd0, reg_rdata}, 0);
    check("R1 reset oc", {29'd0, oc_flags}, 0);
    check("R1 reset irq", {31'd0, irq}, 0);
    model_on = 1;

    // R4 falling edge on bus line
    bus_rx = 0; step();
    check("R4 fall sets", {31'd0, reg_rdata[5]}, 1);
    bus_rx = 1; step();
    check("R4 stays after rise", {31'd0, reg_rdata[5]}, 1);
    reg_we = 1; reg_wdata = 8'h00; step();
    check("R3 write0 keeps", {31'd0, reg_rdata[5]}, 1);
    reg_wdata = 8'h81; step();
    check("R2 reserved bits", {30'd0, reg_rdata[7], reg_rdata[0]}, 0);
    reg_wdata = 8'h20; #1;
    check("R12 read before write", {31'd0, reg_rdata[5]}, 1);
    step(); idle_bus();
    check("R3 w1c clears", {31'd0, reg_rdata[5]}, 0);

    // R5 run-mode Hall
    hall_en = 3'b001; hall_in = 3'b010; step();
    check("R5 disabled change ignored", {31'd0, reg_rdata[6]}, 0);
    hall_in = 3'b011; step();
    check("R5 enabled change sets", {31'd0, reg_rdata[6]}, 1);
    reg_we = 1; reg_wdata = 8'h40; step(); idle_bus();
    check("R3 hall cleared", {31'd0, reg_rdata[6]}, 0);

    // R6 stop-mode Hall
    stop_mode = 1; wake_en = 0; step();
    check("R6 no wake no set", {31'd0, reg_rdata[6]}, 0);
    wake_en = 1; step();
    check("R6 wake and high sets", {31'd0, reg_rdata[6]}, 1);
    stop_mode = 0; wake_en = 0; reg_we = 1; reg_wdata = 8'h40; step(); idle_bus();
    check("R6 cleared after return", {31'd0, reg_rdata[6]}, 0);

    // R7 level flags
    temp_hi = 1; volt_lo = 1; step();
    check("R7 temp set", {31'd0, reg_rdata[4]}, 1);
    reg_we = 1; reg_wdata = 8'h18; step(); idle_bus();
    check("R7 clear refused while active", {30'd0, reg_rdata[4:3]}, 2'b11);
    temp_hi = 0; volt_lo = 0; step();
    reg_we = 1; reg_wdata = 8'h18; step(); idle_bus();
    check("R7 clear after condition gone", {30'd0, reg_rdata[4:3]}, 0);
    volt_hi = 1; step(); volt_hi = 0; step();
    check("R7 ov sticky", {31'd0, reg_rdata[2]}, 1);
    reg_we = 1; reg_wdata = 8'h04; step(); idle_bus();

    // R10 set wins
    bus_rx = 0; reg_we = 1; reg_wdata = 8'h20; step(); idle_bus();
    check("R10 set beats clear", {31'd0, reg_rdata[5]}, 1);
    bus_rx = 1; reg_we = 1; reg_wdata = 8'h20; step(); idle_bus();

    // R8/R9 over-current
    oc_evt = 3'b010; step(); idle_bus();
    check("R9 oc set", {29'd0, oc_flags}, 3'b010);
    check("R8 ocf is or", {31'd0, reg_rdata[1]}, 1);
    reg_we = 1; reg_wdata = 8'h02; step(); idle_bus();
    check("R8 write ignored", {31'd0, reg_rdata[1]}, 1);
    oc_clr_we = 1; oc_clr_data = 3'b001; step(); idle_bus();
    check("R9 other bit clear no effect", {29'd0, oc_flags}, 3'b010);
    oc_clr_we = 1; oc_clr_data = 3'b010; step(); idle_bus();
    check("R9 clear", {29'd0, oc_flags}, 0);
    oc_evt = 3'b100; oc_clr_we = 1; oc_clr_data = 3'b100; step(); idle_bus();
    check("R10 oc set beats clear", {29'd0, oc_flags}, 3'b100);

    // R11 interrupt masking
    irq_mask = 6'b000000; #1;
    check("R11 all masked", {31'd0, irq}, 0);
    irq_mask = 6'b000001; #1;
    check("R11 oc enabled", {31'd0, irq}, 1);
    irq_mask = 6'b111110; #1;
    check("R11 oc masked", {31'd0, irq}, 0);
    step();

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      stop_mode = ($urandom % 8) == 0;
      wake_en = $urandom; hall_en = $urandom; hall_in = $urandom;
      bus_rx = ($urandom % 3) != 0;
      temp_hi = ($urandom % 6) == 0; volt_lo = ($urandom % 6) == 0; volt_hi = ($urandom % 6) == 0;
      oc_evt = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
      oc_clr_we = $urandom; oc_clr_data = $urandom;
      reg_we = $urandom; reg_wdata = $urandom; irq_mask = $urandom;
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule